// File: doc/BRIEF.md
# Latency-Counting Issue Queue

This block is the issue stage of an out-of-order core. It holds waiting instructions in a few small in-order FIFO queues. It uses no associative tag matching. Each dispatched instruction carries a dependence-chain identifier, an execution latency and a payload tag. Every instruction of one chain is placed in the same queue, and several chains may share a queue. Only the head of each queue can issue.

Readiness comes from a small table that holds one countdown per chain. When an instruction issues, its chain's countdown is loaded with that instruction's latency. Every nonzero countdown drops by one each cycle. A head whose countdown is 1 becomes ready on the next cycle, and a head whose countdown is 0 is already ready. The selector first issues the oldest head that is about to become ready. Only when there is none does it issue the oldest head that is already ready. Age is a wrapping dispatch sequence number. At most one instruction issues per cycle, and the issue outputs are registered.

Top module: `chainq_issue`

## Requirements
- R1: After synchronous reset, `iss_valid` and `disp_stall` are 0, and no instruction issues until one is dispatched.
- R2: A dispatch whose chain has no instruction pending goes to the queue with the fewest occupied entries, with ties going to the lowest queue index. `iss_qid` reports the queue index (0 to 3).
- R3: While a chain has any instruction pending, further instructions of that chain go to the same queue, even when another queue has more free entries.
- R4: `disp_stall` is 1 exactly when `disp_valid` is 1 and the queue chosen for the request holds 8 entries. A stalled request is not accepted and never issues. At the same time, a request of another chain that targets a non-full queue is accepted.
- R5: Each queue issues strictly in dispatch order. An entry that is ready waits until every older entry in its queue has issued.
- R6: Issuing an instruction of latency L (1 to 7) loads its chain's countdown with L. When nothing else competes, the next instruction of that chain issues exactly L cycles after it.
- R7: A head whose chain countdown is 1 is chosen over any head whose countdown is 0, even an older one. Within one of these classes, the head with the oldest dispatch sequence number wins.
- R8: Age ordering uses a 6-bit wrapping sequence number compared through the sign bit of the difference, so an instruction dispatched just before the wrap is older than one dispatched just after it.
- R9: `flush` empties every queue, clears every chain countdown and pending count, and suppresses the issue output in the cycle after it.
- R10: An instruction dispatched into an idle block, with its chain countdown at 0, appears on `iss_valid`, `iss_tag` and `iss_qid` right after the clock edge that follows the dispatch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discards all queued instructions and countdowns |
| disp_valid | input | 1 | Dispatch request present |
| disp_chain | input | 4 | Dependence-chain identifier of the request |
| disp_lat | input | 3 | Execution latency of the request, 1 to 7 |
| disp_tag | input | 8 | Payload tag carried to the issue port |
| disp_stall | output | 1 | Request cannot be accepted this cycle |
| iss_valid | output | 1 | An instruction issued (registered) |
| iss_tag | output | 8 | Tag of the issued instruction |
| iss_chain | output | 4 | Chain of the issued instruction |
| iss_qid | output | 2 | Queue the issued instruction came from |

## Verification
The assertions check on every cycle that no queue is pushed when full or popped when empty. They also check that a selected head always has a countdown of at most 1, that an about-to-be-ready head wins whenever one exists, and that reset and flush leave every queue empty with no issue. The exact issue cycles can only be shown by the bench's scenarios. These cover latency spacing, steering by occupancy with lowest-index ties, blocking behind an older head in a shared queue, the stall point of a full queue, age order across the sequence wrap, and the clearing of countdowns by flush.

// File: rtl/chq_pkg.sv
package chq_pkg;
  localparam int CHAIN_W = 4;
  localparam int LAT_W   = 3;
  localparam int TAG_W   = 8;
  localparam int AGE_W   = 6;

  typedef struct packed {
    logic [TAG_W-1:0]   tag;
    logic [CHAIN_W-1:0] chain;
    logic [LAT_W-1:0]   lat;
    logic [AGE_W-1:0]   age;
  } chq_entry_t;
endpackage

// File: rtl/chq_fifo.sv
module chq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  // DEPTH must be a power of two so the pointers wrap naturally.
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_p;
  logic [PW-1:0] rd_p;

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else begin
      if (push) wr_p <= wr_p + PW'(1);
      if (pop)  rd_p <= rd_p + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rd_p];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/chq_steer.sv
module chq_steer #(
  parameter int NQ  = 4,
  parameter int CW  = 4,
  localparam int QW = $clog2(NQ)
) (
  input  logic [NQ-1:0][CW-1:0] occ,
  output logic [QW-1:0]         qsel
);
  // Fewest occupied entries wins; strict compare keeps the lowest index on ties.
  always_comb begin
    qsel = '0;
    for (int q = 1; q < NQ; q++) begin
      if (occ[q] < occ[qsel]) qsel = QW'(q);
    end
  end
endmodule

// File: rtl/chq_select.sv
module chq_select #(
  parameter int NQ    = 4,
  parameter int LAT_W = 3,
  parameter int AGE_W = 6,
  localparam int QW   = $clog2(NQ)
) (
  input  logic [NQ-1:0]            hvalid,
  input  logic [NQ-1:0][LAT_W-1:0] hwait,
  input  logic [NQ-1:0][AGE_W-1:0] hage,
  output logic                     fire,
  output logic [QW-1:0]            qsel
);
  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  logic          nxt_hit;
  logic          rdy_hit;
  logic [QW-1:0] nxt_q;
  logic [QW-1:0] rdy_q;

  always_comb begin
    nxt_hit = 1'b0;
    rdy_hit = 1'b0;
    nxt_q   = '0;
    rdy_q   = '0;
    for (int q = 0; q < NQ; q++) begin
      if (hvalid[q] && hwait[q] == LAT_W'(1)) begin
        if (!nxt_hit || older(hage[q], hage[nxt_q])) nxt_q = QW'(q);
        nxt_hit = 1'b1;
      end
      if (hvalid[q] && hwait[q] == '0) begin
        if (!rdy_hit || older(hage[q], hage[rdy_q])) rdy_q = QW'(q);
        rdy_hit = 1'b1;
      end
    end
    fire = nxt_hit || rdy_hit;
    qsel = nxt_hit ? nxt_q : rdy_q;
  end
endmodule

// File: rtl/chainq_issue.sv
module chainq_issue
  import chq_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int DEPTH = 8,
  localparam int QW   = $clog2(NQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               disp_valid,
  input  logic [CHAIN_W-1:0] disp_chain,
  input  logic [LAT_W-1:0]   disp_lat,
  input  logic [TAG_W-1:0]   disp_tag,
  output logic               disp_stall,
  output logic               iss_valid,
  output logic [TAG_W-1:0]   iss_tag,
  output logic [CHAIN_W-1:0] iss_chain,
  output logic [QW-1:0]      iss_qid
);
  localparam int NCH  = 1 << CHAIN_W;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int EW   = $bits(chq_entry_t);

  // Per-chain state: home queue, pending count, issue countdown.
  logic [QW-1:0]    ch_home [NCH];
  logic [CNTW-1:0]  ch_cnt  [NCH];
  logic [LAT_W-1:0] ch_wait [NCH];
  logic [AGE_W-1:0] seq_q;

  logic [NQ-1:0]            q_push, q_pop, q_empty, q_full;
  logic [NQ-1:0][EW-1:0]    q_dout;
  logic [NQ-1:0][CNTW-1:0]  q_occ;
  logic [NQ-1:0][LAT_W-1:0] h_wait;
  logic [NQ-1:0][AGE_W-1:0] h_age;
  logic [NQ-1:0]            h_next;
  chq_entry_t               head_e [NQ];
  chq_entry_t               new_e;
  chq_entry_t               sel_e;

  logic          new_chain, accept, sel_fire, do_issue;
  logic [QW-1:0] steer_q, tgt_q, sel_q;

  // Dispatch side
  assign new_chain  = (ch_cnt[disp_chain] == '0);
  assign tgt_q      = new_chain ? steer_q : ch_home[disp_chain];
  assign disp_stall = disp_valid && q_full[tgt_q];
  assign accept     = disp_valid && !disp_stall && !flush;
  assign new_e      = '{tag: disp_tag, chain: disp_chain, lat: disp_lat, age: seq_q};

  chq_steer #(.NQ(NQ), .CW(CNTW)) u_steer (.occ(q_occ), .qsel(steer_q));

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign q_push[g] = accept && (tgt_q == QW'(g));
    assign q_pop[g]  = do_issue && (sel_q == QW'(g));
    assign head_e[g] = chq_entry_t'(q_dout[g]);
    assign h_wait[g] = ch_wait[head_e[g].chain];
    assign h_age[g]  = head_e[g].age;
    assign h_next[g] = !q_empty[g] && (h_wait[g] == LAT_W'(1));

    chq_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
      .clk(clk), .rst(rst), .clr(flush),
      .push(q_push[g]), .din(new_e),
      .pop(q_pop[g]), .dout(q_dout[g]),
      .empty(q_empty[g]), .full(q_full[g]), .count(q_occ[g])
    );
  end

  // Select side
  chq_select #(.NQ(NQ), .LAT_W(LAT_W), .AGE_W(AGE_W)) u_sel (
    .hvalid(~q_empty), .hwait(h_wait), .hage(h_age),
    .fire(sel_fire), .qsel(sel_q)
  );

  assign do_issue = sel_fire && !flush;
  assign sel_e    = head_e[sel_q];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int c = 0; c < NCH; c++) begin
        ch_cnt[c]  <= '0;
        ch_wait[c] <= '0;
        ch_home[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        ch_cnt[c] <= ch_cnt[c]
                   + CNTW'(accept && disp_chain == CHAIN_W'(c))
                   - CNTW'(do_issue && sel_e.chain == CHAIN_W'(c));
        if (accept && new_chain && disp_chain == CHAIN_W'(c)) ch_home[c] <= tgt_q;
        if (do_issue && sel_e.chain == CHAIN_W'(c)) ch_wait[c] <= sel_e.lat;
        else if (ch_wait[c] != '0)                  ch_wait[c] <= ch_wait[c] - LAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seq_q <= '0;
    else if (accept) seq_q <= seq_q + AGE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      iss_valid <= 1'b0;
      iss_tag   <= '0;
      iss_chain <= '0;
      iss_qid   <= '0;
    end else begin
      iss_valid <= do_issue;
      iss_tag   <= sel_e.tag;
      iss_chain <= sel_e.chain;
      iss_qid   <= sel_q;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!iss_valid && q_occ == '0));
  a_r6_wait_ready: assert property (@(posedge clk) disable iff (rst)
    sel_fire |-> (h_wait[sel_q] <= LAT_W'(1)));
  a_r7_next_first: assert property (@(posedge clk) disable iff (rst)
    (sel_fire && h_next != '0) |-> (h_wait[sel_q] == LAT_W'(1)));
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!iss_valid && q_occ == '0));
endmodule

// File: tb/chainq_issue_tb_top.sv
module chainq_issue_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic       disp_valid = 1'b0;
  logic [3:0] disp_chain = '0;
  logic [2:0] disp_lat = 3'd1;
  logic [7:0] disp_tag = '0;
  logic       disp_stall, iss_valid;
  logic [7:0] iss_tag;
  logic [3:0] iss_chain;
  logic [1:0] iss_qid;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int seq_n = 0;
  int nlog = 0;
  logic [7:0] lg_tag [512];
  int         lg_cyc [512];
  int         lg_q   [512];

  always #4 clk = ~clk;

  chainq_issue dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(disp_valid), .disp_chain(disp_chain), .disp_lat(disp_lat), .disp_tag(disp_tag),
    .disp_stall(disp_stall),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_chain(iss_chain), .iss_qid(iss_qid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && iss_valid && nlog < 512) begin
      lg_tag[nlog] = iss_tag;
      lg_cyc[nlog] = cyc;
      lg_q[nlog]   = int'(iss_qid);
      nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic dispatch(input logic [3:0] ch, input logic [2:0] lat, input logic [7:0] tg,
                          output int t, output bit stalled);
    @(negedge clk);
    disp_valid = 1'b1; disp_chain = ch; disp_lat = lat; disp_tag = tg;
    #1;
    stalled = disp_stall;
    t = cyc + 1;
    if (!stalled) seq_n++;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    disp_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk);
    disp_valid = 1'b0;
    flush = 1'b1;
    @(posedge clk);
    #1 flush = 1'b0;
  endtask

  task automatic expect_iss(input logic [7:0] tg, input int ec, input int eq, input string rq, input int base);
    int idx = -1;
    for (int i = base; i < nlog; i++) if (idx < 0 && lg_tag[i] == tg) idx = i;
    if (idx < 0) chk(1'b0, rq, $sformatf("tag %0h issue cycle", tg), -1, ec);
    else begin
      chk(lg_cyc[idx] == ec, rq, $sformatf("tag %0h issue cycle", tg), lg_cyc[idx], ec);
      chk(lg_q[idx] == eq, rq, $sformatf("tag %0h queue", tg), lg_q[idx], eq);
    end
  endtask

  task automatic expect_none(input logic [7:0] tg, input string rq, input int base);
    int hits = 0;
    for (int i = base; i < nlog; i++) if (lg_tag[i] == tg) hits++;
    chk(hits == 0, rq, $sformatf("tag %0h issue count", tg), hits, 0);
  endtask

  task automatic t_reset();
    int b;
    b = nlog;
    @(negedge clk);
    chk(iss_valid == 1'b0, "R1", "iss_valid after reset", int'(iss_valid), 0);
    chk(disp_stall == 1'b0, "R1", "disp_stall after reset", int'(disp_stall), 0);
    idle(5);
    chk(nlog == b, "R1", "issues while empty", nlog - b, 0);
  endtask

  // Chains 1..4 spread over the queues, chain 5 shares queue 0 behind chain 1.
  task automatic t_steer();
    int b, n, t;
    bit s;
    do_flush();
    b = nlog;
    dispatch(4'd1, 3'd7, 8'h10, n, s);
    dispatch(4'd1, 3'd7, 8'h11, t, s);
    dispatch(4'd1, 3'd7, 8'h12, t, s);
    dispatch(4'd2, 3'd7, 8'h13, t, s);
    dispatch(4'd2, 3'd7, 8'h14, t, s);
    dispatch(4'd3, 3'd7, 8'h15, t, s);
    dispatch(4'd3, 3'd7, 8'h16, t, s);
    dispatch(4'd4, 3'd7, 8'h17, t, s);
    dispatch(4'd4, 3'd7, 8'h18, t, s);
    dispatch(4'd5, 3'd1, 8'h19, t, s);
    idle(25);
    expect_iss(8'h10, n + 1,  0, "R10", b);
    expect_iss(8'h11, n + 8,  0, "R3",  b);
    expect_iss(8'h12, n + 15, 0, "R3",  b);
    expect_iss(8'h13, n + 4,  1, "R2",  b);
    expect_iss(8'h14, n + 11, 1, "R6",  b);
    expect_iss(8'h15, n + 6,  2, "R2",  b);
    expect_iss(8'h16, n + 13, 2, "R6",  b);
    expect_iss(8'h17, n + 9,  3, "R2",  b);
    expect_iss(8'h18, n + 16, 3, "R7",  b);
    expect_iss(8'h19, n + 17, 0, "R5",  b);
  endtask

  // B and C both about to be ready: older B wins. Then G (about to be ready) beats older ready C.
  task automatic t_prio(input logic [7:0] tb, input string rq);
    int b, n, t;
    bit s;
    do_flush();
    b = nlog;
    dispatch(4'd4, 3'd7, tb + 8'd0, n, s);
    dispatch(4'd4, 3'd1, tb + 8'd1, t, s);
    dispatch(4'd5, 3'd5, tb + 8'd2, t, s);
    dispatch(4'd5, 3'd1, tb + 8'd3, t, s);
    dispatch(4'd6, 3'd4, tb + 8'd4, t, s);
    dispatch(4'd6, 3'd1, tb + 8'd5, t, s);
    idle(15);
    expect_iss(tb + 8'd0, n + 1,  0, "R10", b);
    expect_iss(tb + 8'd2, n + 3,  1, "R10", b);
    expect_iss(tb + 8'd4, n + 5,  2, "R2",  b);
    expect_iss(tb + 8'd1, n + 8,  0, rq,    b);
    expect_iss(tb + 8'd5, n + 9,  2, "R7",  b);
    expect_iss(tb + 8'd3, n + 10, 1, rq,    b);
  endtask

  task automatic t_wrap();
    int t;
    bit s;
    while ((seq_n % 64) != 62) dispatch(4'd0, 3'd1, 8'hF0, t, s);
    idle(3);
    t_prio(8'h30, "R8");
  endtask

  task automatic t_stall();
    int b, n, t;
    bit s;
    do_flush();
    b = nlog;
    for (int k = 0; k <= 10; k++) begin
      dispatch(4'd9, 3'd7, 8'h40 + 8'(k), t, s);
      if (k == 0) n = t;
      chk(s == (k == 10), "R4", $sformatf("stall on request %0d", k), int'(s), int'(k == 10));
    end
    dispatch(4'd10, 3'd1, 8'h60, t, s);
    chk(s == 1'b0, "R4", "stall for other chain", int'(s), 0);
    idle(70);
    expect_iss(8'h60, n + 12, 1, "R4", b);
    for (int i = 0; i < 10; i++) expect_iss(8'h40 + 8'(i), n + 1 + 7 * i, 0, "R6", b);
    expect_none(8'h4A, "R4", b);
  endtask

  task automatic t_flush();
    int b, n, t;
    bit s;
    do_flush();
    b = nlog;
    dispatch(4'd3, 3'd7, 8'h70, n, s);
    dispatch(4'd3, 3'd7, 8'h71, t, s);
    do_flush();
    dispatch(4'd3, 3'd1, 8'h72, t, s);
    idle(15);
    chk(disp_stall == 1'b0, "R9", "disp_stall after flush", int'(disp_stall), 0);
    expect_iss(8'h70, n + 1, 0, "R9", b);
    expect_none(8'h71, "R9", b);
    expect_iss(8'h72, n + 4, 0, "R9", b);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_steer();
    t_prio(8'h20, "R7");
    t_wrap();
    t_stall();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule